// File: doc/BRIEF.md
# Timer Output Compare Channel Bank

This block holds three 16-bit compare values and checks each one against a shared free-running count on every clock. The count arrives as an input, and a counter enable input gates all comparisons. When the count equals a channel's value, that channel raises a sticky match flag. On the same edge it applies a per-channel pin action: hold, toggle, drive low or drive high. Software reaches everything through a plain 8-bit register bus. A channel whose action is "none" still matches and flags, and its register can serve as general read-write storage.

Each compare value is split into a high byte at an even address and a low byte at the next odd address. A coherent update writes the high byte first and the low byte on the next cycle. A high-byte write blocks that channel's comparison for exactly the following cycle, so a value that is only half updated can never produce a match. Single-byte writes are also allowed. The register bus is a control path with no flow control: a write takes effect at the edge where it is presented, and a read is combinational from the presented address.

Top module: `occ_bank`

## Requirements
- R1: Compare register k (k = 0..2) is mapped with its high byte at address 2k and its low byte at address 2k+1. A write stores the byte at the clock edge, and a read (bus_we low) returns the stored byte in the same cycle.
- R2: After reset every compare register reads 0xFFFF, the action and flag registers read 0x00, and pin_out and match_flag are 0.
- R3: At a rising edge where cnt_en is 1, cnt_val equals compare register k and channel k is not inhibited, match_flag[k] becomes 1 and the action of channel k is applied to pin_out[k], both visible after that edge.
- R4: A write to the high byte of channel k at edge E blocks channel k's match at edge E+1 only. A low-byte write blocks nothing.
- R5: While cnt_en is 0, no channel matches: flags and pins are left unchanged.
- R6: Address 6 holds the actions. Bits [2k+1:2k] belong to channel k, with the encoding 00 none (pin holds), 01 toggle, 10 drive 0, 11 drive 1. Bits 7:6 read 0.
- R7: Address 7 bits [2:0] hold the sticky match flags, and these are also driven on match_flag. Writing 1 to a bit clears it and writing 0 has no effect. If a match and a clear hit the same edge, the flag ends at 1. Bits 7:3 read 0.
- R8: Reads of addresses 8 to 15 return 0x00, and writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cnt_en | input | 1 | Counter enable; comparisons only run when high |
| cnt_val | input | 16 | Shared free-running count |
| pin_out | output | 3 | Per-channel compare pin |
| match_flag | output | 3 | Per-channel sticky match flag |

## Verification
If a stored byte is wrong, it shows on bus_rdata as soon as that address is read. It also shows as a missing or spurious match flag on the first edge where the count reaches the intended or the corrupted value. An inhibit that is stuck, or that lasts one cycle too long or too short, is exposed by presenting the matching count exactly one edge after a high-byte write and again one edge later. A wrong action or flag state shows on pin_out and match_flag right after the next matching edge, because the bench compares both ports on every cycle.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } occ_act_e;
endpackage

// File: rtl/occ_regfile.sv
module occ_regfile #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W,
  localparam int ACT_ADDR = 2 * NUM_CH,
  localparam int FLAG_ADDR = 2 * NUM_CH + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_o,
  output logic [NUM_CH-1:0][1:0]         act_o,
  output logic [NUM_CH-1:0]              inhibit_o,
  output logic [NUM_CH-1:0]              flag_clr_o
);
  logic act_sel;
  logic flag_sel;

  assign act_sel  = we && (addr == ADDR_W'(ACT_ADDR));
  assign flag_sel = we && (addr == ADDR_W'(FLAG_ADDR));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hi_sel, lo_sel;
    assign hi_sel = we && (addr == ADDR_W'(2 * i));
    assign lo_sel = we && (addr == ADDR_W'(2 * i + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_o[i]     <= '1;
        act_o[i]     <= occ_pkg::ACT_NONE;
        inhibit_o[i] <= 1'b0;
      end else begin
        inhibit_o[i] <= hi_sel;
        if (hi_sel) cmp_o[i][CNT_W-1:DATA_W] <= wdata;
        if (lo_sel) cmp_o[i][DATA_W-1:0] <= wdata;
        if (act_sel) act_o[i] <= wdata[2*i +: 2];
      end
    end

    assign flag_clr_o[i] = flag_sel && wdata[i];
  end
endmodule

// File: rtl/occ_channel.sv
module occ_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       act_i,
  input  logic             inhibit_i,
  input  logic             flag_clr_i,
  output logic             match_o,
  output logic             pin_o,
  output logic             flag_o
);
  import occ_pkg::*;

  occ_act_e act;
  assign act = occ_act_e'(act_i);
  assign match_o = cnt_en && (cnt_val == cmp_i) && !inhibit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      flag_o <= match_o | (flag_o & ~flag_clr_i);
      if (match_o) begin
        case (act)
          ACT_TOGGLE: pin_o <= ~pin_o;
          ACT_CLEAR:  pin_o <= 1'b0;
          ACT_SET:    pin_o <= 1'b1;
          default:    pin_o <= pin_o;
        endcase
      end
    end
  end
endmodule

// File: rtl/occ_rdmux.sv
module occ_rdmux #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W,
  localparam int ACT_ADDR = 2 * NUM_CH,
  localparam int FLAG_ADDR = 2 * NUM_CH + 1
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_i,
  input  logic [NUM_CH-1:0][1:0]       act_i,
  input  logic [NUM_CH-1:0]            flag_i,
  output logic [DATA_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(2 * i)) rdata = cmp_i[i][CNT_W-1:DATA_W];
      if (addr == ADDR_W'(2 * i + 1)) rdata = cmp_i[i][DATA_W-1:0];
    end
    if (addr == ADDR_W'(ACT_ADDR)) begin
      for (int i = 0; i < NUM_CH; i++) rdata[2*i +: 2] = act_i[i];
    end
    if (addr == ADDR_W'(FLAG_ADDR)) begin
      for (int i = 0; i < NUM_CH; i++) rdata[i] = flag_i[i];
    end
  end
endmodule

// File: rtl/occ_bank.sv
module occ_bank #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_en,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [NUM_CH-1:0] pin_out,
  output logic [NUM_CH-1:0] match_flag
);
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  logic [NUM_CH-1:0][1:0]       act;
  logic [NUM_CH-1:0]            inhibit;
  logic [NUM_CH-1:0]            flag_clr;
  logic [NUM_CH-1:0]            match_pulse;

  occ_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cmp_o(cmp), .act_o(act), .inhibit_o(inhibit), .flag_clr_o(flag_clr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    occ_channel #(.CNT_W(CNT_W)) ch_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_val(cnt_val),
      .cmp_i(cmp[i]), .act_i(act[i]), .inhibit_i(inhibit[i]),
      .flag_clr_i(flag_clr[i]), .match_o(match_pulse[i]),
      .pin_o(pin_out[i]), .flag_o(match_flag[i])
    );
  end

  occ_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_i (
    .addr(bus_addr), .cmp_i(cmp), .act_i(act), .flag_i(match_flag), .rdata(bus_rdata)
  );
endmodule

// File: rtl/occ_bank_checker.sv
module occ_bank_checker #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4,
  localparam int FLAG_ADDR = 2 * NUM_CH + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NUM_CH-1:0] clr_bits,
  input logic              cnt_en,
  input logic [NUM_CH-1:0] match_pulse,
  input logic [NUM_CH-1:0] pin_out,
  input logic [NUM_CH-1:0] match_flag
);
  // R5: a disabled counter produces no match on any channel
  a_r5_no_match_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> (match_pulse == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R4: cycle after a high-byte write never matches
    a_r4_inhibit_window: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(2 * i)) |=> !match_pulse[i]);
    // R3: a match leaves the flag set
    a_r3_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse[i] |=> match_flag[i]);
    // R7: flag stays set without a clear
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag[i] && !(bus_we && bus_addr == ADDR_W'(FLAG_ADDR) && clr_bits[i]))
      |=> match_flag[i]);
    // R6: pin changes only on a match edge
    a_r6_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !match_pulse[i] |=> $stable(pin_out[i]));
  end
endmodule

bind occ_bank occ_bank_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .clr_bits(bus_wdata[NUM_CH-1:0]), .cnt_en(cnt_en), .match_pulse(match_pulse),
  .pin_out(pin_out), .match_flag(match_flag)
);

// File: tb/occ_bank_tb.sv
`timescale 1ns/1ps
module occ_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_en = 1'b0;
  logic [15:0] cnt_val = '0;
  logic [2:0] pin_out, match_flag;

  int n_checks = 0;
  int n_fail = 0;

  logic [15:0] m_cmp [3];
  logic [1:0]  m_act [3];
  logic [2:0]  m_flag, m_pin, m_inh;

  always #2 clk = ~clk;

  occ_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
    .cnt_val(cnt_val), .pin_out(pin_out), .match_flag(match_flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] a);
    logic [7:0] r = 8'h00;
    if (a < 4'd6) r = a[0] ? m_cmp[a/2][7:0] : m_cmp[a/2][15:8];
    else if (a == 4'd6) r = {2'b00, m_act[2], m_act[1], m_act[0]};
    else if (a == 4'd7) r = {5'b0, m_flag};
    return r;
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    if (a < 4'd6) return "R1 read";
    if (a == 4'd6) return "R6 read";
    if (a == 4'd7) return "R7 read";
    return "R8 read";
  endfunction

  function automatic logic pin_next(input logic [1:0] act, input logic cur);
    case (act)
      2'b01: return ~cur;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin m_cmp[k] = 16'hFFFF; m_act[k] = 2'b00; end
    m_flag = '0; m_pin = '0; m_inh = '0;
  endtask

  // Called just after a falling edge; applies one bus cycle.
  task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                      input logic en, input logic [15:0] c, input string tag);
    logic [2:0] mt, ninh;
    bus_we = we; bus_addr = a; bus_wdata = d; cnt_en = en; cnt_val = c;
    #1;
    if (!we) chk(rd_tag(a), {8'h00, bus_rdata}, {8'h00, m_read(a)});
    for (int k = 0; k < 3; k++) begin
      mt[k] = en && (c == m_cmp[k]) && !m_inh[k];
      ninh[k] = we && (a == 4'(2 * k));
    end
    for (int k = 0; k < 3; k++) begin
      if (mt[k]) m_pin[k] = pin_next(m_act[k], m_pin[k]);
      m_flag[k] = mt[k] | (m_flag[k] & ~(we && a == 4'd7 && d[k]));
      if (we && a == 4'(2 * k)) m_cmp[k][15:8] = d;
      if (we && a == 4'(2 * k + 1)) m_cmp[k][7:0] = d;
      if (we && a == 4'd6) m_act[k] = d[2*k +: 2];
    end
    m_inh = ninh;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " pin"}, {13'b0, pin_out}, {13'b0, m_pin});
    chk({tag, " flag"}, {13'b0, match_flag}, {13'b0, m_flag});
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset values
    chk("R2 pins", {13'b0, pin_out}, 16'h0);
    chk("R2 flags", {13'b0, match_flag}, 16'h0);
    for (int a = 0; a < 8; a++) step(1'b0, 4'(a), 8'h00, 1'b0, 16'h0000, "R2");
    // R1: store and read back channel 1
    step(1'b1, 4'd2, 8'hA5, 1'b0, 16'h0000, "R1");
    step(1'b1, 4'd3, 8'h5A, 1'b0, 16'h0000, "R1");
    step(1'b0, 4'd2, 8'h00, 1'b0, 16'h0000, "R1");
    step(1'b0, 4'd3, 8'h00, 1'b0, 16'h0000, "R1");
    // R5: matching count but counter disabled
    step(1'b0, 4'd0, 8'h00, 1'b0, 16'hA55A, "R5");
    // R6: ch0 toggle, ch1 set, ch2 clear
    step(1'b1, 4'd6, 8'h2D, 1'b0, 16'h0000, "R6");
    step(1'b0, 4'd0, 8'h00, 1'b1, 16'hA55A, "R3 R6 set");
    chk("R6 pin1 set", {15'b0, pin_out[1]}, 16'h1);
    // R7: clear flag 1, writing 0 elsewhere is harmless
    step(1'b1, 4'd7, 8'h02, 1'b0, 16'h0000, "R7 clear");
    chk("R7 cleared", {15'b0, match_flag[1]}, 16'h0);
    // R4: inhibit window after high-byte write; ch1 toggles
    step(1'b1, 4'd6, 8'h25, 1'b0, 16'h0000, "R6");
    step(1'b1, 4'd2, 8'hA5, 1'b1, 16'h0000, "R4 write");
    step(1'b0, 4'd7, 8'h00, 1'b1, 16'hA55A, "R4 blocked");
    chk("R4 no match", {15'b0, match_flag[1]}, 16'h0);
    step(1'b0, 4'd7, 8'h00, 1'b1, 16'hA55A, "R4 after");
    chk("R4 match", {15'b0, match_flag[1]}, 16'h1);
    chk("R4 toggled", {15'b0, pin_out[1]}, 16'h0);
    // R4: low-byte write does not inhibit
    step(1'b1, 4'd3, 8'h5A, 1'b1, 16'h0000, "R4 low");
    step(1'b1, 4'd7, 8'h02, 1'b1, 16'hA55A, "R7 priority");
    chk("R7 match beats clear", {15'b0, match_flag[1]}, 16'h1);
    // R8: writes to unused addresses change nothing
    step(1'b1, 4'd9, 8'hFF, 1'b0, 16'h0000, "R8 write");
    step(1'b0, 4'd9, 8'h00, 1'b0, 16'h0000, "R8");
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic we_r;
      logic [3:0] a_r;
      logic [15:0] c_r;
      we_r = ($urandom % 10) < 4;
      a_r = 4'($urandom % 16);
      if (we_r && ($urandom % 4 != 0)) a_r = 4'($urandom % 8);
      c_r = ($urandom % 2) ? m_cmp[$urandom % 3] : 16'($urandom);
      step(we_r, a_r, 8'($urandom), ($urandom % 10) != 0, c_r, "R3 random");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule